// File: doc/BRIEF.md
# Two-Page Program Cache Loader

This block keeps a small coprocessor's program memory as two pages of 256 sixteen-bit words. Each page carries a tag, which is the 24-bit bank address of the code it holds. When the sequencer asks for a program bank, the block forms the bank address and compares it against the tags. A hit only changes which page is active. On a miss the block picks a victim page while honouring per-page lock bits, then reloads it from an external memory bus. The bus hands back a byte pair for each word. Every word costs a number of cycles set by the memory region being read.

The sequencer gets a one-cycle pulse for a hit, for a failure, or for the end of a refill. It also sees a busy level while a refill is in progress. When the 8-bit program counter wraps, the sequencer raises a wrap request. On page 0 the block moves to page 1 and looks up the bank held in the page-pointer input. On page 1 the wrap is a failure, and the processor is expected to halt. A combinational read port returns the stored word of the active page at a given index.

Top module: `pcl_cache_loader`

## Requirements
- R1: The bank address is `base_addr + bank * 512`, taken modulo 2^24. A refill starts reading at exactly that byte address and advances by 2 bytes per word, wrapping at 2^24.
- R2: A lookup first compares the tag of the active page and then the tag of the other page. A match on either is a hit: `hit` pulses in the cycle after the request, the matching page becomes active, `busy` stays low and no memory request is made. Lock bits do not block a hit.
- R3: On a miss the victim is the other page unless it is locked. If the other page is locked, the victim is the active page. If both pages are locked, `fail` pulses and the active page does not change. `lock_cfg` bit 0 locks page 0 and bit 1 locks page 1.
- R4: A refill stores the bank address as the victim's tag and makes the victim the active page. It then writes 256 words, where word i = {byte[A+2i+1], byte[A+2i]}. A later lookup of the same bank hits.
- R5: Each word costs 1 cycle plus a wait count, judged on the address of its low byte. In the ROM region the wait is `wait_cfg[6:4]`. In the RAM region it is `wait_cfg[2:0]`. In any other region it is 0. `mem_addr` is held for all cycles of the word, and `busy` is high for exactly the sum of the word costs.
- R6: `busy` rises in the cycle after an accepted miss and falls after the last word is written. `refill_done` pulses for one cycle as `busy` falls. Lookup and wrap requests made while `busy` is high are ignored.
- R7: A wrap request while page 1 is active gives `fail`, and page 1 stays active.
- R8: A wrap request while page 0 is active makes page 1 active. If page 1 is locked, the result is `fail`. Otherwise a lookup of bank `page_ptr` runs with page 1 as the first page compared.
- R9: After reset, page 0 is active, `busy`, `hit`, `fail`, `refill_done` and `mem_req` are low, and both tags are invalid, so the first lookup always misses.
- R10: When `wrap_req` and `lookup_req` are both high in the same cycle, the wrap is served and the lookup is dropped.
- R11: `fetch_word` is the word stored in the active page at `fetch_idx`, read combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_req | input | 1 | Request a lookup of `bank_num` |
| bank_num | input | 15 | Program bank number for a lookup |
| wrap_req | input | 1 | Program counter wrapped |
| page_ptr | input | 15 | Bank number loaded on a wrap from page 0 |
| base_addr | input | 24 | Base byte address of the bank space |
| lock_cfg | input | 2 | Per-page lock bits (bit n locks page n) |
| wait_cfg | input | 8 | RAM wait in [2:0], ROM wait in [6:4] |
| mem_req | output | 1 | Memory read in progress |
| mem_addr | output | 24 | Byte address of the low byte of the current word |
| mem_rdata | input | 16 | Byte pair {byte[addr+1], byte[addr]} |
| mem_is_rom | input | 1 | `mem_addr` decodes to the ROM region |
| mem_is_ram | input | 1 | `mem_addr` decodes to the RAM region |
| fetch_idx | input | 8 | Word index for the read port |
| fetch_word | output | 16 | Word of the active page at `fetch_idx` |
| active_page | output | 1 | Currently active page |
| busy | output | 1 | Refill in progress |
| hit | output | 1 | Lookup hit pulse |
| fail | output | 1 | Lookup or wrap failure pulse |
| refill_done | output | 1 | Refill completion pulse |

## Verification
The hardest situation to reach is a victim choice that falls back to the active page. For that, both pages must hold valid and different tags, the other page must be locked, and the request must still miss. The directed sequence builds it step by step. It fills page 1, then page 0, moves back to page 1 with a hit, and then locks page 0 before requesting a third bank. A seeded random phase then draws banks from a small set so that hits, refills and lock failures mix. One bank crosses a region boundary and one wraps the 24-bit address, so a single refill charges two different wait counts.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    parameter int ADDR_W     = 24;
    parameter int BANK_W     = 15;
    parameter int BANK_SHIFT = 9;
    parameter int IDX_W      = 8;
    parameter int WORD_W     = 16;
    parameter int WAIT_W     = 3;
    parameter int PAGES      = 2;

    localparam int WORDS = 1 << IDX_W;
    localparam int CNT_W = WAIT_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
    } tag_t;

    typedef enum logic [1:0] {RES_NONE, RES_HIT, RES_FILL, RES_FAIL} res_e;

    function automatic addr_t bank_base(addr_t base, logic [BANK_W-1:0] bank);
        return base + (addr_t'(bank) << BANK_SHIFT);
    endfunction

    function automatic cnt_t word_cost(logic rom, logic ram,
                                       logic [WAIT_W-1:0] rom_w,
                                       logic [WAIT_W-1:0] ram_w);
        cnt_t extra;
        extra = rom ? cnt_t'(rom_w) : (ram ? cnt_t'(ram_w) : '0);
        return cnt_t'(1) + extra;
    endfunction
endpackage

// File: rtl/pcl_tag_bank.sv
module pcl_tag_bank
    import pcl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_lookup,
    input  logic  acc_wrap,
    input  addr_t lookup_addr,
    input  logic [PAGES-1:0] lock,
    output logic  page_q,
    output logic  hit_o,
    output logic  fail_o,
    output logic  fill_go,
    output addr_t fill_addr
);
    tag_t [PAGES-1:0] tags;
    res_e res;
    logic eff, other, vic, next_page, hit_cur, hit_oth;

    always_comb begin
        eff       = acc_wrap ? 1'b1 : page_q;
        other     = ~eff;
        hit_cur   = tags[eff].valid   && (tags[eff].addr   == lookup_addr);
        hit_oth   = tags[other].valid && (tags[other].addr == lookup_addr);
        vic       = lock[other] ? eff : other;
        res       = RES_NONE;
        next_page = page_q;
        if (acc_wrap && (page_q || lock[1])) begin
            res       = RES_FAIL;
            next_page = 1'b1;
        end else if (acc_lookup || acc_wrap) begin
            if (hit_cur) begin
                res = RES_HIT;  next_page = eff;
            end else if (hit_oth) begin
                res = RES_HIT;  next_page = other;
            end else if (lock[vic]) begin
                res = RES_FAIL; next_page = eff;
            end else begin
                res = RES_FILL; next_page = vic;
            end
        end
    end

    assign fill_go   = (res == RES_FILL);
    assign fill_addr = lookup_addr;

    for (genvar g = 0; g < PAGES; g++) begin : g_tag
        tag_t tag_q;
        always_ff @(posedge clk) begin
            if (rst)
                tag_q <= '0;
            else if (fill_go && (vic == 1'(g)))
                tag_q <= '{valid: 1'b1, addr: lookup_addr};
        end
        assign tags[g] = tag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= 1'b0;
            hit_o  <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            page_q <= next_page;
            hit_o  <= (res == RES_HIT);
            fail_o <= (res == RES_FAIL);
        end
    end

    // R3: a refill never targets a locked page
    p_fill_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        fill_go |-> !lock[vic]);

    // R7: wrap while on page 1 fails and stays on page 1
    p_wrap_top_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_wrap && page_q) |=> (fail_o && page_q));

    // R8: wrap from page 0 into a locked page 1 fails on page 1
    p_wrap_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_wrap && !page_q && lock[1]) |=> (fail_o && page_q));
endmodule

// File: rtl/pcl_refill.sv
module pcl_refill
    import pcl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t start_addr,
    input  logic  is_rom,
    input  logic  is_ram,
    input  logic [WAIT_W-1:0] rom_wait,
    input  logic [WAIT_W-1:0] ram_wait,
    input  logic [WORD_W-1:0] rdata,
    output logic  busy,
    output logic  mem_req,
    output addr_t mem_addr,
    output logic  wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic  done
);
    logic busy_q;
    addr_t addr_q;
    logic [IDX_W-1:0] idx_q;
    cnt_t cnt_q, cost;

    assign cost     = word_cost(is_rom, is_ram, rom_wait, ram_wait);
    assign wr_en    = busy_q && (cnt_q == cost - cnt_t'(1));
    assign wr_idx   = idx_q;
    assign wr_data  = rdata;
    assign busy     = busy_q;
    assign mem_req  = busy_q;
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done   <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy_q && start) begin
                busy_q <= 1'b1;
                addr_q <= start_addr;
                idx_q  <= '0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (wr_en) begin
                    cnt_q  <= '0;
                    addr_q <= addr_q + addr_t'(2);
                    idx_q  <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(WORDS - 1)) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R5: the word address holds until the word is taken
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !wr_en) |=> (busy_q && $stable(mem_addr)));

    // R6: completion pulse only as busy falls
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/pcl_page_store.sv
module pcl_page_store
    import pcl_pkg::*;
(
    input  logic clk,
    input  logic we,
    input  logic wpage,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic rpage,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [PAGES][WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[wpage][widx] <= wdata;
    end

    assign rdata = mem[rpage][ridx];
endmodule

// File: rtl/pcl_cache_loader.sv
module pcl_cache_loader
    import pcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_req,
    input  logic [BANK_W-1:0] bank_num,
    input  logic              wrap_req,
    input  logic [BANK_W-1:0] page_ptr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [PAGES-1:0]  lock_cfg,
    input  logic [7:0]        wait_cfg,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_is_rom,
    input  logic              mem_is_ram,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic [WORD_W-1:0] fetch_word,
    output logic              active_page,
    output logic              busy,
    output logic              hit,
    output logic              fail,
    output logic              refill_done
);
    logic  idle, acc_lookup, acc_wrap, fill_go, wr_en;
    addr_t lookup_addr, fill_addr;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic unused_cfg_bits;

    assign unused_cfg_bits = wait_cfg[7] ^ wait_cfg[3];
    assign idle        = !busy;
    assign acc_wrap    = wrap_req && idle;
    assign acc_lookup  = lookup_req && idle && !wrap_req;
    assign lookup_addr = bank_base(base_addr, wrap_req ? page_ptr : bank_num);

    pcl_tag_bank u_tags (
        .clk(clk), .rst(rst), .acc_lookup(acc_lookup), .acc_wrap(acc_wrap),
        .lookup_addr(lookup_addr), .lock(lock_cfg), .page_q(active_page),
        .hit_o(hit), .fail_o(fail), .fill_go(fill_go), .fill_addr(fill_addr)
    );

    pcl_refill u_refill (
        .clk(clk), .rst(rst), .start(fill_go), .start_addr(fill_addr),
        .is_rom(mem_is_rom), .is_ram(mem_is_ram),
        .rom_wait(wait_cfg[6:4]), .ram_wait(wait_cfg[2:0]),
        .rdata(mem_rdata), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(refill_done)
    );

    pcl_page_store u_store (
        .clk(clk), .we(wr_en), .wpage(active_page), .widx(wr_idx),
        .wdata(wr_data), .rpage(active_page), .ridx(fetch_idx),
        .rdata(fetch_word)
    );

    // R2: a hit never comes with refill traffic
    p_hit_idle_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> !busy);

    // R6: requests during a refill produce no result
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!hit && !fail));
endmodule

// File: tb/test_pcl_cache_loader.sv
`timescale 1ns/1ps
module test_pcl_cache_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lookup_req = 1'b0, wrap_req = 1'b0;
    logic [14:0] bank_num = '0, page_ptr = '0;
    logic [23:0] base_addr = 24'h000100;
    logic [1:0]  lock_cfg = 2'b00;
    logic [7:0]  wait_cfg = 8'h21;
    logic        mem_req, active_page, busy, hit, fail, refill_done;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata, fetch_word;
    logic        mem_is_rom, mem_is_ram;
    logic [7:0]  fetch_idx = '0;

    int tests = 0, fails = 0;
    logic [23:0] m_tag [2];
    bit m_val [2];
    bit m_page;

    always #4 clk = ~clk;

    function automatic logic [7:0] mb(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic int region_wait(logic [23:0] a, logic [7:0] cfg);
        if (a[23]) return int'(cfg[6:4]);
        if (a[23:22] == 2'b01) return int'(cfg[2:0]);
        return 0;
    endfunction

    function automatic int exp_cost(logic [23:0] a0, logic [7:0] cfg);
        int s = 0;
        for (int i = 0; i < 256; i++) begin
            logic [23:0] a = a0 + 24'(2 * i);
            s += 1 + region_wait(a, cfg);
        end
        return s;
    endfunction

    function automatic logic [15:0] exp_word(logic [23:0] a0, int i);
        logic [23:0] a = a0 + 24'(2 * i);
        return {mb(a + 24'd1), mb(a)};
    endfunction

    assign mem_is_rom = mem_addr[23];
    assign mem_is_ram = (mem_addr[23:22] == 2'b01);
    assign mem_rdata  = {mb(mem_addr + 24'd1), mb(mem_addr)};

    pcl_cache_loader i_pcl_cache_loader (
        .clk(clk), .rst(rst), .lookup_req(lookup_req), .bank_num(bank_num),
        .wrap_req(wrap_req), .page_ptr(page_ptr), .base_addr(base_addr),
        .lock_cfg(lock_cfg), .wait_cfg(wait_cfg), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_is_rom(mem_is_rom),
        .mem_is_ram(mem_is_ram), .fetch_idx(fetch_idx), .fetch_word(fetch_word),
        .active_page(active_page), .busy(busy), .hit(hit), .fail(fail),
        .refill_done(refill_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [14:0] bank, input bit wrap,
                          input bit both, input bit intrude, input string req);
        logic [23:0] a;
        bit eff, oth, vic;
        int kind, n, cost;
        a = base_addr + {bank, 9'b0};
        if (wrap && (m_page || lock_cfg[1])) begin
            kind = 2; m_page = 1'b1;
        end else begin
            eff = wrap ? 1'b1 : m_page;
            oth = !eff;
            if (m_val[eff] && m_tag[eff] == a) begin
                kind = 0; m_page = eff;
            end else if (m_val[oth] && m_tag[oth] == a) begin
                kind = 0; m_page = oth;
            end else begin
                vic = lock_cfg[oth] ? eff : oth;
                if (lock_cfg[vic]) begin
                    kind = 2; m_page = eff;
                end else begin
                    kind = 1; m_page = vic; m_tag[vic] = a; m_val[vic] = 1'b1;
                end
            end
        end
        cost = exp_cost(a, wait_cfg);
        bank_num = bank; page_ptr = bank;
        wrap_req = wrap; lookup_req = !wrap || both;
        @(negedge clk);
        lookup_req = 1'b0; wrap_req = 1'b0;
        chk(req, "hit", 32'(hit), 32'(kind == 0));
        chk(req, "fail", 32'(fail), 32'(kind == 2));
        chk(req, "busy", 32'(busy), 32'(kind == 1));
        chk(req, "page", 32'(active_page), 32'(m_page));
        if (kind == 1) begin
            chk("R1", "first address", 32'(mem_addr), 32'(a));
            n = 0;
            while (busy && n < 5000) begin
                n++;
                if (intrude && n == 11)
                    chk("R6", "no result while busy", 32'({hit, fail}), 32'(0));
                lookup_req = intrude && (n == 10);
                wrap_req   = intrude && (n == 10);
                @(negedge clk);
            end
            lookup_req = 1'b0; wrap_req = 1'b0;
            chk("R5", "busy cycles", 32'(n), 32'(cost));
            chk("R6", "done pulse", 32'(refill_done), 32'(1));
            chk("R4", "page after fill", 32'(active_page), 32'(m_page));
            for (int k = 0; k < 4; k++) begin
                int idx = (k == 0) ? 0 : (k == 1) ? 255 : int'($urandom_range(1, 254));
                fetch_idx = 8'(idx);
                #1;
                chk("R4", "word", 32'(fetch_word), 32'(exp_word(a, idx)));
            end
            @(negedge clk);
            chk("R6", "done one cycle", 32'(refill_done), 32'(0));
        end else begin
            chk("R2", "no memory request", 32'(mem_req), 32'(0));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [14:0] pool [5];
        pool = '{15'h0010, 15'h2010, 15'h4010, 15'h1FFF, 15'h7FFF};
        void'($urandom(32'd17));
        m_val[0] = 0; m_val[1] = 0; m_page = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "reset busy", 32'(busy), 0);
        chk("R9", "reset page", 32'(active_page), 0);
        chk("R9", "reset pulses", 32'({hit, fail, refill_done, mem_req}), 0);

        do_req(15'h1FFF, 0, 0, 0, "R9");   // first miss, region crossing fill of page 1
        do_req(15'h1FFF, 0, 0, 0, "R2");   // hit on active page
        do_req(15'h4010, 0, 0, 0, "R3");   // fill other page 0
        do_req(15'h1FFF, 0, 0, 0, "R2");   // hit on other page
        lock_cfg = 2'b01;
        do_req(15'h7FFF, 0, 0, 0, "R3");   // fallback victim: active page 1, wraps 2^24
        lock_cfg = 2'b11;
        do_req(15'h0010, 0, 0, 0, "R3");   // both locked -> fail
        do_req(15'h4010, 0, 0, 0, "R2");   // hit despite locks
        lock_cfg = 2'b00;
        do_req(15'h7FFF, 1, 0, 0, "R8");   // wrap from page 0, hit on page 1
        do_req(15'h7FFF, 1, 0, 0, "R7");   // wrap on page 1 -> fail
        do_req(15'h4010, 0, 0, 0, "R2");
        lock_cfg = 2'b10;
        do_req(15'h0010, 1, 0, 0, "R8");   // wrap into locked page 1
        lock_cfg = 2'b00;
        do_req(15'h0010, 1, 1, 0, "R10");  // both requests, wrap wins -> fail
        wait_cfg = 8'h53;
        do_req(15'h0010, 0, 0, 1, "R6");   // fill with ignored requests
        do_req(15'h7FFF, 0, 0, 0, "R6");   // state untouched by ignored ones

        for (int it = 0; it < 24; it++) begin
            lock_cfg = 2'($urandom_range(0, 3));
            wait_cfg = 8'($urandom) & 8'h77;
            do_req(pool[$urandom_range(0, 4)], ($urandom_range(0, 3) == 0), 0, 0, "R11");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule